// File: doc/BRIEF.md
# Host-to-SRAM Word Bridge

This block lets a 32-bit host request port read and write a synchronous SRAM whose words are 36 bits wide. Each host request is one beat. In narrow mode, a beat moves only the low 32 bits of a memory word. In wide mode, a memory word is split across a pair of beats: the first beat carries the top nibble and the second beat carries the low 32 bits. A wide write is held inside the bridge until both beats have arrived, and only then does it reach the memory.

While the bridge owns the SRAM port, it drives a mux select so that user logic is cut off from that port. In preemptive mode, the bridge first asks for the user clock to be stopped. It then waits for the stopped acknowledge before it takes the port, and keeps the stop request up until it hands the port back. In non-preemptive mode, the user clock keeps running and the port is simply taken for the length of the access. The SRAM may run flow-through, returning read data one cycle after the enable, or pipelined, which adds one more cycle.

Both host channels are valid/ready. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high, and only one beat is in flight at a time: `req_ready` is high only while the bridge is idle. A response is held with its data unchanged until `rsp_ready` is seen high at a clock edge. The three mode pins are sampled when a beat is accepted.

Top module: `hmb_top`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid`, `mem_sel`, `mem_en` and `clk_stop_req` are all 0.
- R2: In narrow mode (`cfg_wide`=0), a read beat returns bits [31:0] of the addressed word. A write beat stores `{4'b0000, req_wdata}`, so the top nibble becomes zero.
- R3: In wide mode, beats alternate between first and second. A first read beat returns bits [35:32] of the word in `rsp_rdata[3:0]`, with the upper bits zero. The second read beat returns bits [31:0]. A first write beat supplies bits [35:32] in `req_wdata[3:0]`. The second write beat supplies bits [31:0]. The address of the pair is the one given with the first beat, and the address given with the second beat is ignored. Any narrow-mode beat returns the pairing to the first position.
- R4: In wide mode, a first write beat and a second read beat make no memory access. A second write beat makes exactly one memory write. A first read beat makes exactly one memory read.
- R5: In preemptive mode (`cfg_preempt`=1), the bridge raises `clk_stop_req` before it takes the port. It does not pulse `mem_en` until `clk_stopped` is 1, and it holds `clk_stop_req` until `mem_sel` falls.
- R6: In non-preemptive mode, `clk_stop_req` stays 0. `mem_sel` is 1 only during the bridge's own access, and `mem_en` is never 1 while `mem_sel` is 0.
- R7: Read data is captured from `mem_rdata` one cycle after the `mem_en` cycle when `cfg_pipelined`=0, and two cycles after it when `cfg_pipelined`=1.
- R8: Once `rsp_valid` is high, it stays high and `rsp_rdata` stays stable until a clock edge with `rsp_ready` high. While a response is pending, `req_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wide | input | 1 | 1: two beats per 36-bit word; 0: one beat of 32 bits |
| cfg_preempt | input | 1 | 1: stop the user clock while accessing |
| cfg_pipelined | input | 1 | 1: SRAM has one more cycle of read latency |
| req_valid | input | 1 | Host beat offered |
| req_ready | output | 1 | Bridge can accept a beat |
| req_we | input | 1 | 1: write beat, 0: read beat |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | HOST_W | Write data for this beat |
| rsp_valid | output | 1 | Beat completed, data valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_rdata | output | HOST_W | Read data for this beat (zero for writes) |
| clk_stop_req | output | 1 | Request to stop the user clock |
| clk_stopped | input | 1 | User clock is stopped |
| mem_sel | output | 1 | 1: the SRAM port is driven by the bridge |
| mem_en | output | 1 | SRAM access strobe |
| mem_we | output | 1 | SRAM write enable |
| mem_addr | output | ADDR_W | SRAM address |
| mem_wdata | output | MEM_W | SRAM write word |
| mem_rdata | input | MEM_W | SRAM read word |

## Verification
A wrong beat phase shows up on the next wide beat in two ways: the data lands in the wrong place, and the count of memory strobes no longer matches the number of beats. The bench counts strobes per beat, so this is flagged within one beat. A wrong latency setting captures the filler value the bench memory drives outside valid read cycles, so the very first read of that mode returns a wrong value. A missing handshake with the clock-stop acknowledge is seen in the same cycle as the strobe, because the bench monitors the strobe against the acknowledge.

// File: rtl/hmb_pkg.sv
package hmb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACQ,
    ST_ACC,
    ST_WAIT,
    ST_RESP
  } hmb_state_e;
endpackage

// File: rtl/hmb_pack.sv
module hmb_pack #(
  parameter int HOST_W = 32,
  parameter int MEM_W  = 36,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              wide,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [HOST_W-1:0] wdata,
  input  logic              cap,
  input  logic [MEM_W-1:0]  mem_rdata,
  output logic              need_mem,
  output logic [ADDR_W-1:0] word_addr,
  output logic [MEM_W-1:0]  word_wdata,
  output logic [HOST_W-1:0] beat_rdata
);
  localparam int EXT_W = MEM_W - HOST_W;
  localparam int PAD_W = HOST_W - EXT_W;

  logic              phase_q;
  logic              wide_q;
  logic [EXT_W-1:0]  hi_q;
  logic [ADDR_W-1:0] pair_addr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [HOST_W-1:0] wdata_q;
  logic [HOST_W-1:0] low_q;
  logic [HOST_W-1:0] rdata_q;

  // a beat needs the SRAM unless it is the nibble half of a write or
  // the low half of a read already fetched
  assign need_mem = !wide || (we ? phase_q : !phase_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q     <= 1'b0;
      wide_q      <= 1'b0;
      hi_q        <= '0;
      pair_addr_q <= '0;
      addr_q      <= '0;
      wdata_q     <= '0;
      low_q       <= '0;
      rdata_q     <= '0;
    end else if (take) begin
      wide_q  <= wide;
      wdata_q <= wdata;
      phase_q <= wide & ~phase_q;
      if (wide && !phase_q) begin
        pair_addr_q <= addr;
        if (we) hi_q <= wdata[EXT_W-1:0];
      end
      addr_q  <= (wide && phase_q) ? pair_addr_q : addr;
      rdata_q <= (wide && phase_q && !we) ? low_q : '0;
    end else if (cap) begin
      low_q   <= mem_rdata[HOST_W-1:0];
      rdata_q <= wide_q ? {{PAD_W{1'b0}}, mem_rdata[MEM_W-1:HOST_W]}
                        : mem_rdata[HOST_W-1:0];
    end
  end

  assign word_addr  = addr_q;
  assign word_wdata = wide_q ? {hi_q, wdata_q} : {{EXT_W{1'b0}}, wdata_q};
  assign beat_rdata = rdata_q;
endmodule

// File: rtl/hmb_lat.sv
module hmb_lat #(
  parameter int FLOW_LAT = 1,
  parameter int PIPE_ADD = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic pipe,
  output logic fire
);
  localparam int MAX_LAT = FLOW_LAT + PIPE_ADD;
  localparam int CNT_W   = $clog2(MAX_LAT + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (start)          cnt_q <= pipe ? CNT_W'(MAX_LAT) : CNT_W'(FLOW_LAT);
    else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
  end

  assign fire = (cnt_q == CNT_W'(1));

  AST_LAT_IDLE_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> cnt_q == '0); // R7
endmodule

// File: rtl/hmb_seq.sv
module hmb_seq
  import hmb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_we,
  input  logic cfg_preempt,
  input  logic cfg_pipelined,
  input  logic need_mem,
  input  logic clk_stopped,
  input  logic lat_fire,
  input  logic rsp_ready,
  output logic req_ready,
  output logic take,
  output logic clk_stop_req,
  output logic mem_sel,
  output logic mem_en,
  output logic mem_we,
  output logic lat_start,
  output logic lat_pipe,
  output logic cap,
  output logic rsp_valid
);
  hmb_state_e state_q, state_d;
  logic pre_q, we_q, pipe_q;

  always_comb begin
    state_d      = state_q;
    req_ready    = 1'b0;
    take         = 1'b0;
    clk_stop_req = 1'b0;
    mem_sel      = 1'b0;
    mem_en       = 1'b0;
    lat_start    = 1'b0;
    cap          = 1'b0;
    rsp_valid    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        req_ready = 1'b1;
        take      = req_valid;
        if (req_valid) state_d = need_mem ? ST_ACQ : ST_RESP;
      end
      ST_ACQ: begin
        clk_stop_req = pre_q;
        if (!pre_q || clk_stopped) state_d = ST_ACC;
      end
      ST_ACC: begin
        clk_stop_req = pre_q;
        mem_sel      = 1'b1;
        mem_en       = 1'b1;
        lat_start    = !we_q;
        state_d      = we_q ? ST_RESP : ST_WAIT;
      end
      ST_WAIT: begin
        clk_stop_req = pre_q;
        mem_sel      = 1'b1;
        cap          = lat_fire;
        if (lat_fire) state_d = ST_RESP;
      end
      ST_RESP: begin
        rsp_valid = 1'b1;
        if (rsp_ready) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pre_q   <= 1'b0;
      we_q    <= 1'b0;
      pipe_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (take) begin
        pre_q  <= cfg_preempt;
        we_q   <= req_we;
        pipe_q <= cfg_pipelined;
      end
    end
  end

  assign mem_we   = mem_en & we_q;
  assign lat_pipe = pipe_q;

  AST_OWN_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && pre_q) |-> clk_stopped); // R5
  AST_NP_NO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_sel && !pre_q) |-> !clk_stop_req); // R6
endmodule

// File: rtl/hmb_top.sv
module hmb_top #(
  parameter int HOST_W   = 32,
  parameter int MEM_W    = 36,
  parameter int ADDR_W   = 10,
  parameter int FLOW_LAT = 1,
  parameter int PIPE_ADD = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wide,
  input  logic              cfg_preempt,
  input  logic              cfg_pipelined,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [HOST_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [HOST_W-1:0] rsp_rdata,
  output logic              clk_stop_req,
  input  logic              clk_stopped,
  output logic              mem_sel,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [MEM_W-1:0]  mem_wdata,
  input  logic [MEM_W-1:0]  mem_rdata
);
  logic take, need_mem, lat_start, lat_pipe, lat_fire, cap;

  hmb_seq u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .cfg_preempt(cfg_preempt), .cfg_pipelined(cfg_pipelined),
    .need_mem(need_mem), .clk_stopped(clk_stopped), .lat_fire(lat_fire),
    .rsp_ready(rsp_ready), .req_ready(req_ready), .take(take),
    .clk_stop_req(clk_stop_req), .mem_sel(mem_sel), .mem_en(mem_en),
    .mem_we(mem_we), .lat_start(lat_start), .lat_pipe(lat_pipe),
    .cap(cap), .rsp_valid(rsp_valid)
  );

  hmb_pack #(.HOST_W(HOST_W), .MEM_W(MEM_W), .ADDR_W(ADDR_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .take(take), .wide(cfg_wide), .we(req_we),
    .addr(req_addr), .wdata(req_wdata), .cap(cap), .mem_rdata(mem_rdata),
    .need_mem(need_mem), .word_addr(mem_addr), .word_wdata(mem_wdata),
    .beat_rdata(rsp_rdata)
  );

  hmb_lat #(.FLOW_LAT(FLOW_LAT), .PIPE_ADD(PIPE_ADD)) u_lat (
    .clk(clk), .rst_n(rst_n), .start(lat_start), .pipe(lat_pipe),
    .fire(lat_fire)
  );

  AST_RSP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata))); // R8
  AST_EN_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> mem_sel); // R6
endmodule

// File: tb/hmb_top_tb.sv
`timescale 1ns/1ps
module hmb_top_tb;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wide = 1'b0, cfg_preempt = 1'b0, cfg_pipelined = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, rsp_ready = 1'b1;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, clk_stop_req, mem_sel, mem_en, mem_we;
  logic [31:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic [35:0] mem_wdata, mem_rdata;
  logic clk_stopped;

  int n_cmp = 0, n_bad = 0, en_cnt = 0, viol = 0;
  bit stop_seen = 0;

  always #2.5 clk = ~clk;

  hmb_top #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_preempt(cfg_preempt),
    .cfg_pipelined(cfg_pipelined), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .clk_stop_req(clk_stop_req), .clk_stopped(clk_stopped), .mem_sel(mem_sel),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // bench SRAM: filler outside the valid read slot
  logic [35:0] bmem [2**AW];
  logic [35:0] r1, r2;
  initial for (int i = 0; i < 2**AW; i++) bmem[i] = 36'h0;
  always @(posedge clk) begin
    if (mem_en && mem_we) bmem[mem_addr] <= mem_wdata;
    r1 <= (mem_en && !mem_we) ? bmem[mem_addr] : 36'hA_5A5A_5A5A;
    r2 <= r1;
  end
  assign mem_rdata = cfg_pipelined ? r2 : r1;

  // user clock stopper: acknowledges 3 cycles after request, drops 1 after release
  int stop_cnt = 0;
  always @(posedge clk) begin
    if (!clk_stop_req) stop_cnt <= 0;
    else if (stop_cnt < 3) stop_cnt <= stop_cnt + 1;
  end
  assign clk_stopped = (stop_cnt == 3);

  always @(posedge clk) if (rst_n) begin
    if (mem_en) en_cnt <= en_cnt + 1;
    if (clk_stop_req) stop_seen <= 1;
    if (mem_en && !mem_sel) viol <= viol + 1;
    if (cfg_preempt && mem_en && !clk_stopped) viol <= viol + 1;
    if (!cfg_preempt && clk_stop_req) viol <= viol + 1;
  end

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic beat(input logic we, input logic [AW-1:0] a, input logic [31:0] d,
                      output logic [31:0] q);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    q = rsp_rdata;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] q;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 req_ready", 36'(req_ready), 36'd1);
    chk("R1 rsp_valid", 36'(rsp_valid), 36'd0);
    chk("R1 mem_sel", 36'(mem_sel), 36'd0);
    chk("R1 mem_en", 36'(mem_en), 36'd0);
    chk("R1 clk_stop_req", 36'(clk_stop_req), 36'd0);

    for (int c = 0; c < 8; c++) begin
      cfg_wide = c[0]; cfg_preempt = c[1]; cfg_pipelined = c[2];
      stop_seen = 0; viol = 0;
      for (int a = 0; a < 4; a++) begin
        logic [AW-1:0] ad;
        logic [3:0] hi;
        logic [31:0] lo;
        int e0;
        ad = AW'(c * 4 + a);
        hi = 4'((c * 3 + a + 5) % 16);
        lo = 32'h1357_0000 ^ (32'(c) << 12) ^ (32'(a) * 32'h0101_0011);
        if (!cfg_wide) begin
          beat(1'b1, ad, lo, q);
          chk("R2 narrow write zero-fills top", bmem[ad], {4'h0, lo});
          beat(1'b0, ad, 32'h0, q);
          chk("R2 R7 narrow read", 36'(q), 36'(lo));
        end else begin
          e0 = en_cnt;
          beat(1'b1, ad, {28'h0, hi}, q);
          chk("R4 first write beat no access", 36'(en_cnt), 36'(e0));
          beat(1'b1, ~ad, lo, q);
          chk("R4 second write beat one access", 36'(en_cnt), 36'(e0 + 1));
          chk("R3 wide word stored at first address", bmem[ad], {hi, lo});
          beat(1'b0, ad, 32'h0, q);
          chk("R3 R7 first read beat nibble", 36'(q), 36'(hi));
          chk("R4 first read beat one access", 36'(en_cnt), 36'(e0 + 2));
          beat(1'b0, ~ad, 32'h0, q);
          chk("R3 second read beat low", 36'(q), 36'(lo));
          chk("R4 second read beat no access", 36'(en_cnt), 36'(e0 + 2));
        end
      end
      chk("R5 R6 ownership violations", 36'(viol), 36'd0);
      chk("R5 R6 stop request seen", 36'(stop_seen), 36'(cfg_preempt));
    end

    // narrow beat resets pairing; narrow view of wide word
    cfg_wide = 1'b1; cfg_preempt = 1'b0; cfg_pipelined = 1'b1;
    beat(1'b1, 6'd40, 32'hF, q);
    cfg_wide = 1'b0;
    beat(1'b0, 6'd5, 32'h0, q);
    chk("R2 narrow read low bits of wide word", 36'(q), 36'(bmem[5][31:0]));
    cfg_wide = 1'b1;
    beat(1'b1, 6'd41, 32'h6, q);
    beat(1'b1, 6'd41, 32'hCAFE_0042, q);
    chk("R3 phase reset by narrow beat", bmem[41], 36'h6_CAFE_0042);
    cfg_wide = 1'b0;
    beat(1'b1, 6'd41, 32'h1111_2222, q);
    cfg_wide = 1'b1;
    beat(1'b0, 6'd41, 32'h0, q);
    chk("R2 narrow write cleared top nibble", 36'(q), 36'd0);
    beat(1'b0, 6'd41, 32'h0, q);

    // back-pressure on the response
    cfg_wide = 1'b0; cfg_preempt = 1'b1; cfg_pipelined = 1'b0;
    rsp_ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = 6'd41;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    q = rsp_rdata;
    chk("R8 held read data", 36'(q), 36'h1111_2222);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R8 rsp_valid held", 36'(rsp_valid), 36'd1);
      chk("R8 rsp_rdata stable", 36'(rsp_rdata), 36'(q));
      chk("R8 req_ready low while pending", 36'(req_ready), 36'd0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R8 response retired", 36'(rsp_valid), 36'd0);
    chk("R5 clock released", 36'(clk_stop_req), 36'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule